// File: doc/BRIEF.md
# DC-Balanced Block Line Encoder

This block turns a stream of 3-bit data groups into 4-bit codewords whose ones and zeros cancel over time, so a frequency-modulated radio carrier sees no net DC shift. Six of the eight groups have a codeword with exactly two ones. The groups 000 and 111 each have two complementary codewords. A single shared bit of state records whether the most recent of those special codewords was the "A" variant (the one with three ones), and the next special group then takes the other variant.

A control input selects a second line code instead. In that mode the low data bit of each group is sent as a two-element symbol. A built-in serializer shifts each codeword out MSB first, one element per enable tick. The input side takes a group through a valid/ready handshake and stays not-ready while elements remain to be sent. During the tick that sends the final element it is ready again, so the line runs without gaps. Each accepted codeword also appears in parallel on an output with a one-cycle valid flag.

Top module: `dc_balanced_encoder`

## Requirements
- R1: Balanced groups map as 001→1100, 010→0011, 011→1010, 100→0101, 101→1001, 110→0110 (codeword written MSB first).
- R2: Group 000 maps to 1011 (A) or 0100 (B), and group 111 maps to 1101 (A) or 0010 (B). A special group takes B when the last special codeword was A and takes A otherwise, with one flag shared by both groups. The sequence 000,000,000 gives 1011,0100,1011, and 111,111,010,110,000 gives 1101,0010,0011,0110,1011.
- R3: After reset the flag is clear, the block is in block-code mode, `in_ready` is 1, and `ser_valid` and `cw_valid` are 0.
- R4: Balanced groups leave the flag unchanged. The flag changes only when a group is accepted (`in_valid` and `in_ready` both high at a clock edge).
- R5: With `enc_sel`=1, data bit 0 = 0 is sent as symbol 10 and 1 as 01. The symbol occupies `cw_out[3:2]`, `cw_out[1:0]` is 00, and two elements are serialized.
- R6: `enc_sel` is taken only with an accepted group. When its value differs from that of the previous accepted group, the flag is cleared before that group is encoded.
- R7: `ser_out` presents the codeword MSB first. It advances one element on each clock edge where `elem_tick` is 1 and holds otherwise. `ser_valid` is 1 while elements remain.
- R8: `in_ready` is 1 when no elements remain, or when exactly one remains and `elem_tick` is 1. Otherwise it is 0. With `elem_tick` held at 1 and groups always offered, `ser_valid` never drops between codewords.
- R9: One cycle after an accepted group, `cw_valid` pulses for one cycle with that group's codeword on `cw_out`, and the first element is on `ser_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_sel | input | 1 | Line code for the offered group: 0 block code, 1 two-element symbol |
| in_valid | input | 1 | Data group offered |
| in_data | input | 3 | Data group |
| in_ready | output | 1 | Group can be accepted this cycle |
| elem_tick | input | 1 | Element-rate enable for the serializer |
| ser_out | output | 1 | Serial element, MSB first |
| ser_valid | output | 1 | `ser_out` carries an unsent element |
| cw_out | output | 4 | Last accepted codeword, parallel |
| cw_valid | output | 1 | One-cycle pulse when `cw_out` updates |

## Verification
The sending of a codeword's final element and the loading of the next codeword can fall in the same clock edge, because `in_ready` rises combinationally with `elem_tick` on the last element. The bench provokes this by holding the tick high and offering groups back to back. It judges the result by the element order seen by the scoreboard and by finding no cycle in that window with `ser_valid` low. A mode switch and a special group can also coincide at one acceptance. The bench sends a special group right after a switch and expects the A word, where a stale flag would give B.

// File: rtl/lenc_pkg.sv
package lenc_pkg;

   typedef enum logic {
      LC_BLOCK = 1'b0,
      LC_SYMB  = 1'b1
   } lc_mode_e;

   localparam int unsigned GRP_W = 3;
   localparam int unsigned CW_W  = 4;
   localparam int unsigned SYM_W = 2;

   localparam logic [CW_W-1:0] ZERO_A = 4'b1011;
   localparam logic [CW_W-1:0] ZERO_B = 4'b0100;
   localparam logic [CW_W-1:0] ONES_A = 4'b1101;
   localparam logic [CW_W-1:0] ONES_B = 4'b0010;

   localparam logic [SYM_W-1:0] SYM_FOR_0 = 2'b10;
   localparam logic [SYM_W-1:0] SYM_FOR_1 = 2'b01;

   // Two-ones codeword for the six groups that have a single choice.
   function automatic logic [CW_W-1:0] bal_word(input logic [GRP_W-1:0] g);
      logic [CW_W-1:0] w;
      case (g)
         3'b001:  w = 4'b1100;
         3'b010:  w = 4'b0011;
         3'b011:  w = 4'b1010;
         3'b100:  w = 4'b0101;
         3'b101:  w = 4'b1001;
         3'b110:  w = 4'b0110;
         default: w = 4'b0000;
      endcase
      return w;
   endfunction

endpackage

// File: rtl/lenc_mapper.sv
module lenc_mapper
   import lenc_pkg::*;
#(
   parameter int unsigned DATA_W = 3,
   parameter int unsigned WORD_W = 4,
   parameter int unsigned MAN_W  = 2,
   localparam int unsigned LEN_W = $clog2(WORD_W + 1)
) (
   input  logic [DATA_W-1:0] grp,
   input  lc_mode_e          mode,
   input  logic              last_a,
   output logic [WORD_W-1:0] word,
   output logic [LEN_W-1:0]  len,
   output logic              special
);

   generate
      if (DATA_W != GRP_W) begin : g_bad_data
         $error("lenc_mapper: DATA_W must equal 3");
      end
      if (WORD_W != CW_W) begin : g_bad_word
         $error("lenc_mapper: WORD_W must equal 4");
      end
      if (MAN_W != SYM_W || MAN_W > WORD_W) begin : g_bad_sym
         $error("lenc_mapper: MAN_W must equal 2");
      end
   endgenerate

   localparam logic [LEN_W-1:0] BLK_LEN = LEN_W'(WORD_W);
   localparam logic [LEN_W-1:0] SYM_LEN = LEN_W'(MAN_W);

   logic is_zero, is_ones;
   logic [WORD_W-1:0] blk_word;
   logic [MAN_W-1:0]  sym;

   assign is_zero = (grp == '0);
   assign is_ones = (grp == '1);

   always_comb begin
      if (is_zero)      blk_word = last_a ? ZERO_B : ZERO_A;
      else if (is_ones) blk_word = last_a ? ONES_B : ONES_A;
      else              blk_word = bal_word(grp);
   end

   assign sym = grp[0] ? SYM_FOR_1 : SYM_FOR_0;

   always_comb begin
      if (mode == LC_SYMB) begin
         word    = {sym, {(WORD_W-MAN_W){1'b0}}};
         len     = SYM_LEN;
         special = 1'b0;
      end else begin
         word    = blk_word;
         len     = BLK_LEN;
         special = is_zero | is_ones;
      end
   end

endmodule

// File: rtl/lenc_alt_state.sv
module lenc_alt_state
   import lenc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     accept,
   input  lc_mode_e mode_in,
   input  logic     special,
   output lc_mode_e mode_act,
   output logic     last_a_use
);

   logic     last_a_q;
   lc_mode_e mode_q;
   logic     mode_chg;

   assign mode_chg   = (mode_in != mode_q);
   assign last_a_use = mode_chg ? 1'b0 : last_a_q;
   assign mode_act   = mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_a_q <= 1'b0;
         mode_q   <= LC_BLOCK;
      end else if (accept) begin
         mode_q <= mode_in;
         if (special)       last_a_q <= ~last_a_use;
         else if (mode_chg) last_a_q <= 1'b0;
      end
   end

endmodule

// File: rtl/lenc_shifter.sv
module lenc_shifter #(
   parameter int unsigned WORD_W = 4,
   localparam int unsigned LEN_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              tick,
   output logic              ser_out,
   output logic              busy,
   output logic              can_take
);

   generate
      if (WORD_W < 2) begin : g_bad_w
         $error("lenc_shifter: WORD_W must be at least 2");
      end
   endgenerate

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic [WORD_W-1:0] sreg;
   logic [LEN_W-1:0]  left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sreg <= '0;
         left <= '0;
      end else if (load) begin
         sreg <= load_word;
         left <= load_len;
      end else if (tick && left != '0) begin
         sreg <= {sreg[WORD_W-2:0], 1'b0};
         left <= left - ONE;
      end
   end

   assign ser_out  = sreg[WORD_W-1];
   assign busy     = (left != '0);
   assign can_take = (left == '0) || (left == ONE && tick);

endmodule

// File: rtl/dc_balanced_encoder.sv
module dc_balanced_encoder
   import lenc_pkg::*;
#(
   parameter int unsigned DATA_W = 3,
   parameter int unsigned WORD_W = 4,
   parameter int unsigned MAN_W  = 2,
   localparam int unsigned LEN_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enc_sel,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              elem_tick,
   output logic              ser_out,
   output logic              ser_valid,
   output logic [WORD_W-1:0] cw_out,
   output logic              cw_valid
);

   lc_mode_e          mode_in, mode_act;
   logic              accept, last_a_use, special;
   logic [WORD_W-1:0] word;
   logic [LEN_W-1:0]  len;
   logic [WORD_W-1:0] cw_q;
   logic              cw_v_q;

   assign mode_in = enc_sel ? LC_SYMB : LC_BLOCK;
   assign accept  = in_valid & in_ready;

   lenc_alt_state u_state (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .mode_in    (mode_in),
      .special    (special),
      .mode_act   (mode_act),
      .last_a_use (last_a_use)
   );

   lenc_mapper #(
      .DATA_W (DATA_W),
      .WORD_W (WORD_W),
      .MAN_W  (MAN_W)
   ) u_map (
      .grp     (in_data),
      .mode    (mode_in),
      .last_a  (last_a_use),
      .word    (word),
      .len     (len),
      .special (special)
   );

   lenc_shifter #(
      .WORD_W (WORD_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_word (word),
      .load_len  (len),
      .tick      (elem_tick),
      .ser_out   (ser_out),
      .busy      (ser_valid),
      .can_take  (in_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cw_q   <= '0;
         cw_v_q <= 1'b0;
      end else begin
         cw_v_q <= accept;
         if (accept) cw_q <= word;
      end
   end

   assign cw_out   = cw_q;
   assign cw_valid = cw_v_q;

endmodule

// File: rtl/lenc_checker.sv
module lenc_checker #(
   parameter int unsigned WORD_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic              elem_tick,
   input logic              ser_out,
   input logic              ser_valid,
   input logic [WORD_W-1:0] cw_out,
   input logic              cw_valid,
   input logic              mode_act
);

   logic seen_a, prev_mode;
   logic is_spec, is_a, is_b;

   assign is_a    = (cw_out == 4'b1011) || (cw_out == 4'b1101);
   assign is_b    = (cw_out == 4'b0100) || (cw_out == 4'b0010);
   assign is_spec = is_a | is_b;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_a    <= 1'b0;
         prev_mode <= 1'b0;
      end else if (cw_valid) begin
         prev_mode <= mode_act;
         if (mode_act != prev_mode)           seen_a <= !mode_act && is_a;
         else if (!mode_act && is_spec)       seen_a <= is_a;
      end
   end

   // R8
   idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_valid |-> in_ready);

   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_valid && !elem_tick |-> !in_ready);

   // R7
   hold_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_valid && !elem_tick |=> ser_valid && $stable(ser_out));

   // R9
   load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> cw_valid && ser_valid);

   // R9
   pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid && !(in_valid && in_ready) |=> !cw_valid);

   // R5
   symb_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid && mode_act |-> (cw_out[3] != cw_out[2]) && (cw_out[1:0] == 2'b00));

   // R1
   block_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid && !mode_act |-> ($countones(cw_out) == 2) || is_spec);

   // R2
   alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid && !mode_act && !prev_mode && seen_a && is_spec |-> is_b);

endmodule

bind dc_balanced_encoder lenc_checker #(.WORD_W(WORD_W)) u_lenc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .elem_tick (elem_tick),
   .ser_out   (ser_out),
   .ser_valid (ser_valid),
   .cw_out    (cw_out),
   .cw_valid  (cw_valid),
   .mode_act  (mode_act)
);

// File: tb/test_dc_balanced_encoder.sv
`timescale 1ns/1ps
module test_dc_balanced_encoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enc_sel = 1'b0;
   logic       in_valid = 1'b0;
   logic [2:0] in_data = 3'b000;
   logic       in_ready;
   logic       elem_tick = 1'b0;
   logic       ser_out, ser_valid, cw_valid;
   logic [3:0] cw_out;

   always #4 clk = ~clk;

   dc_balanced_encoder i_dc_balanced_encoder (
      .clk       (clk),
      .rst_n     (rst_n),
      .enc_sel   (enc_sel),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_ready  (in_ready),
      .elem_tick (elem_tick),
      .ser_out   (ser_out),
      .ser_valid (ser_valid),
      .cw_out    (cw_out),
      .cw_valid  (cw_valid)
   );

   int    n_chk = 0;
   int    n_bad = 0;
   logic  cw_q[$];
   logic  [3:0] cwv_q[$];
   string cwt_q[$];
   logic  el_q[$];
   string elt_q[$];
   logic  m_last_a = 1'b0;
   logic  m_mode = 1'b0;
   logic  tick_all = 1'b1;
   logic  [7:0] lfsr = 8'hA5;
   logic  win = 1'b0;
   int    gaps = 0;

   task automatic check(input logic ok, input string tag, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // element-rate enable, changed well after the active edge
   initial forever begin
      @(posedge clk);
      #2;
      elem_tick = tick_all ? 1'b1 : lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   end

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (cw_valid) begin
            if (cwv_q.size() == 0) check(1'b0, "R9", "unexpected cw", cw_out, 0);
            else begin
               logic [3:0] e;
               string t;
               e = cwv_q.pop_front();
               t = cwt_q.pop_front();
               check(cw_out == e, t, "codeword", cw_out, e);
            end
         end
         if (ser_valid && elem_tick) begin
            if (el_q.size() == 0) check(1'b0, "R7", "unexpected element", ser_out, 0);
            else begin
               logic e;
               string t;
               e = el_q.pop_front();
               t = elt_q.pop_front();
               check(ser_out == e, t, "element", ser_out, e);
            end
         end
         if (win && !ser_valid) gaps++;
      end
   end

   function automatic logic [3:0] model_word(input logic [2:0] d, input logic man);
      logic [3:0] w;
      if (man) w = d[0] ? 4'b0100 : 4'b1000;
      else begin
         case (d)
            3'd0: w = m_last_a ? 4'b0100 : 4'b1011;
            3'd7: w = m_last_a ? 4'b0010 : 4'b1101;
            3'd1: w = 4'b1100;
            3'd2: w = 4'b0011;
            3'd3: w = 4'b1010;
            3'd4: w = 4'b0101;
            3'd5: w = 4'b1001;
            default: w = 4'b0110;
         endcase
      end
      return w;
   endfunction

   task automatic send(input logic [2:0] d, input logic man, input string tag);
      logic [3:0] w;
      if (man != m_mode) begin
         m_last_a = 1'b0;
         m_mode   = man;
      end
      w = model_word(d, man);
      if (!man && (d == 3'd0 || d == 3'd7)) m_last_a = ~m_last_a;
      cwv_q.push_back(w);
      cwt_q.push_back(tag);
      for (int i = 3; i >= (man ? 2 : 0); i--) begin
         el_q.push_back(w[i]);
         elt_q.push_back(tag);
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = d;
      enc_sel  = man;
      forever begin
         #1;
         if (in_ready) break;
         @(negedge clk);
      end
      @(posedge clk);
      #1;
      in_valid = 1'b0;
   endtask

   task automatic drain();
      while (el_q.size() != 0 || cwv_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      in_valid = 1'b0;
      enc_sel = 1'b0;
      m_last_a = 1'b0;
      m_mode = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_all();
      do_reset();
      @(negedge clk);
      #1;
      // R3 idle state after reset
      check(in_ready == 1'b1, "R3", "in_ready", in_ready, 1);
      check(ser_valid == 1'b0, "R3", "ser_valid", ser_valid, 0);
      check(cw_valid == 1'b0, "R3", "cw_valid", cw_valid, 0);

      // R2 repeated zeros alternate, first one is A (R3)
      tick_all = 1'b1;
      for (int i = 0; i < 3; i++) send(3'd0, 1'b0, "R2");
      drain();

      // R2 shared flag between 000 and 111
      do_reset();
      send(3'd7, 1'b0, "R2"); send(3'd7, 1'b0, "R2"); send(3'd2, 1'b0, "R2");
      send(3'd6, 1'b0, "R2"); send(3'd0, 1'b0, "R2");
      drain();

      // R4 balanced groups keep the flag
      do_reset();
      send(3'd0, 1'b0, "R4"); send(3'd2, 1'b0, "R4");
      send(3'd3, 1'b0, "R4"); send(3'd0, 1'b0, "R4");
      drain();

      // R1 all balanced groups, sparse ticks (R7 hold)
      tick_all = 1'b0;
      for (int g = 1; g <= 6; g++) send(3'(g), 1'b0, "R1");
      drain();

      // R5 symbol mode, sparse ticks
      send(3'd0, 1'b1, "R5"); send(3'd1, 1'b1, "R5");
      send(3'd7, 1'b1, "R5"); send(3'd6, 1'b1, "R5");
      drain();

      // R6 mode switch clears the flag
      tick_all = 1'b1;
      do_reset();
      send(3'd0, 1'b0, "R6"); send(3'd1, 1'b1, "R6");
      send(3'd0, 1'b0, "R6"); send(3'd7, 1'b0, "R6");
      drain();

      // R8 gapless streaming with the tick held high
      send(3'd5, 1'b0, "R8");
      win = 1'b1;
      send(3'd0, 1'b0, "R8"); send(3'd7, 1'b0, "R8"); send(3'd1, 1'b0, "R8");
      send(3'd3, 1'b1, "R8"); send(3'd2, 1'b1, "R8"); send(3'd7, 1'b0, "R8");
      send(3'd4, 1'b0, "R8");
      win = 1'b0;
      drain();
      check(gaps == 0, "R8", "idle cycles while streaming", gaps, 0);
      check(el_q.size() == 0, "R7", "elements left", el_q.size(), 0);
   endtask

   initial begin
      logic wd_hit;
      wd_hit = 1'b0;
      fork
         run_all();
         begin
            repeat (150000) @(posedge clk);
            wd_hit = 1'b1;
         end
      join_any
      disable fork;
      if (wd_hit) begin
         n_chk++;
         n_bad++;
         $display("FAIL R7 watchdog: actual %0d expected %0d", 1, 0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule